// File: doc/BRIEF.md
# I2C Register-File Target

This block is a serial-bus target that presents a small array of byte registers, addressed the way a serial memory device is addressed. A bus controller first selects the target by its 7-bit device address with the direction bit cleared. It then sends a register index, which is one byte or two bytes as chosen by `wide_ptr_i`. Any bytes that follow are written into consecutive registers. A read, either after a fresh START or after a repeated START, returns bytes starting at the current index. The index moves forward by one for every data byte that is written or read.

The bus pins arrive as plain `scl_i` / `sda_i` inputs. The target pulls SDA low through `sda_drive_low_o`, so the board supplies the open-drain wiring and the pull-up. Both bus inputs are resynchronised into `clk_i`. That clock must run at least eight times the SCL rate. Out of reset, every register holds zero.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, and after any STOP (SDA rising while SCL is high), `sda_drive_low_o` is 0 and the target waits for a START (SDA falling while SCL is high).
- R2: When the 7 bits following a START equal `DEV_ADDR` (default 7'h50), sent MSB first, the target holds SDA low for the whole 9th clock of that byte.
- R3: When the address differs, the target never pulls SDA low, and it ignores every byte until the next START. A write attempted in that state leaves all registers unchanged.
- R4: The bit after the address selects the direction: 0 means the controller writes, 1 means the target sends register data starting at the current index.
- R5: With `wide_ptr_i`=0, the first byte after a write address is loaded into the index. The target acknowledges that byte.
- R6: With `wide_ptr_i`=1, the first two bytes after a write address are the index, upper byte first. Both bytes are acknowledged. Only the low log2(DEPTH) bits of the 16-bit value select a register.
- R7: Each byte written after the index is stored at the current index and acknowledged, and the index then increases by one.
- R8: In a read, each byte is sent MSB first and the index increases by one for each byte. The target releases SDA during the 9th clock so that the controller can acknowledge.
- R9: A controller NACK (SDA high on the 9th clock of a read byte) ends output. After that, SDA stays released until STOP or START.
- R10: The index survives STOP and repeated START. A read that follows a write of the index alone returns the register that index selects.
- R11: The index wraps from DEPTH-1 to 0, in both writes and reads.
- R12: The target changes its SDA drive only while SCL is low. Incoming bits are sampled on the rising edge of SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock as seen at the pin |
| sda_i | input | 1 | Bus data as seen at the pin |
| wide_ptr_i | input | 1 | 0: one-byte index, 1: two-byte index, upper byte first |
| sda_drive_low_o | output | 1 | 1 pulls the SDA line low |

## Verification
Each bus input passes through two synchroniser flops and one edge register. A drive change therefore reaches `sda_drive_low_o` three to four system clocks after the SCL edge that causes it, and a captured bit is registered about three clocks after the SCL rise. The bench gives each SCL phase 10 system clocks and changes SDA a quarter period (5 clocks) after SCL falls. It samples the target's ACK and data bits in the middle of the SCL-high phase, which is well past the point where the drive has settled. During reads, each bit is sampled twice within the high phase to show that it holds steady while SCL is high. Register contents are checked only through later reads, compared against a model array that the bench updates from its own writes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR_HI,
    ST_PTR_LO,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // SDA edges with SCL high on both samples
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         DEPTH    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wide_ptr_i,
  output logic sda_drive_low_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e state_q;
  logic [3:0]       bit_cnt_q;
  logic [6:0]       shreg_q;
  logic [7:0]       tx_q, ptr_hi_q, new_byte, rd_data;
  logic [15:0]      ptr_full;
  logic [IDX_W-1:0] ptr_q;
  logic             ack_q, sda_oe_q, wr_en;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign new_byte = {shreg_q, sda_s};
  assign ptr_full = {ptr_hi_q, new_byte};
  assign wr_en    = scl_rise && (bit_cnt_q == 4'd7) && (state_q == ST_WDATA);

  i2c_reg_bank #(.DEPTH(DEPTH)) u_bank (
    .clk_i, .rst_ni, .we_i(wr_en), .waddr_i(ptr_q), .wdata_i(new_byte),
    .raddr_i(ptr_q), .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_hi_q  <= '0;
      ptr_q     <= '0;
      ack_q     <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (scl_rise && state_q != ST_IDLE) begin
      if (bit_cnt_q != 4'd8) begin
        shreg_q   <= new_byte[6:0];
        bit_cnt_q <= bit_cnt_q + 4'd1;
        if (bit_cnt_q == 4'd7) begin
          unique case (state_q)
            ST_ADDR: begin
              if (new_byte[7:1] == DEV_ADDR) begin
                ack_q    <= 1'b1;
                ptr_hi_q <= '0;
                if (new_byte[0])     state_q <= ST_RDATA;
                else if (wide_ptr_i) state_q <= ST_PTR_HI;
                else                 state_q <= ST_PTR_LO;
              end else begin
                state_q <= ST_WAIT;
              end
            end
            ST_PTR_HI: begin
              ptr_hi_q <= new_byte;
              ack_q    <= 1'b1;
              state_q  <= ST_PTR_LO;
            end
            ST_PTR_LO: begin
              ptr_q   <= IDX_W'(ptr_full);
              ack_q   <= 1'b1;
              state_q <= ST_WDATA;
            end
            ST_WDATA: begin
              ptr_q <= ptr_q + IDX_W'(1);
              ack_q <= 1'b1;
            end
            default: ;
          endcase
        end
      end else begin
        bit_cnt_q <= '0;
        // controller NACK on a read byte ends output
        if (state_q == ST_RDATA && sda_s) state_q <= ST_WAIT;
      end
    end else if (scl_fall && state_q != ST_IDLE) begin
      if (bit_cnt_q == 4'd8) begin
        sda_oe_q <= ack_q;
        ack_q    <= 1'b0;
      end else if (state_q == ST_RDATA) begin
        if (bit_cnt_q == 4'd0) begin
          tx_q     <= {rd_data[6:0], 1'b0};
          sda_oe_q <= ~rd_data[7];
          ptr_q    <= ptr_q + IDX_W'(1);
        end else begin
          tx_q     <= {tx_q[6:0], 1'b0};
          sda_oe_q <= ~tx_q[7];
        end
      end else begin
        sda_oe_q <= 1'b0;
      end
    end
  end

  assign sda_drive_low_o = sda_oe_q;

  // R12
  drive_only_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_q));
  // R1
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_drive_low_o);
  // R3
  ignore_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !sda_drive_low_o);
  // R7
  ptr_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (ptr_q == $past(ptr_q) + IDX_W'(1)));
  // R2
  start_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_ADDR && bit_cnt_q == 4'd0 && !sda_oe_q));
endmodule

// File: tb/i2c_regfile_target_test.sv
`timescale 1ns/1ps
module i2c_regfile_target_test;
  localparam int Q = 100;
  localparam logic [6:0] ADDR = 7'h50;
  localparam int DEPTH = 16;
  // {wide, pointer[15:0], data[7:0]}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 16'h0004, 8'h5A}, {1'b0, 16'h0009, 8'hC3},
    {1'b0, 16'h00F7, 8'h11}, {1'b1, 16'h0002, 8'h99},
    {1'b1, 16'h0702, 8'h42}, {1'b1, 16'h000B, 8'hE7},
    {1'b0, 16'h0000, 8'h01}, {1'b1, 16'h00FF, 8'h80}
  };

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, wide = 0;
  logic drv;
  wire  sda_bus = sda_m & ~drv;
  int checks = 0, fails = 0;
  logic [7:0] model [DEPTH];
  logic done = 0;

  always #10 clk = ~clk;

  i2c_regfile_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .wide_ptr_i(wide), .sda_drive_low_o(drv)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_c();
    sda_m = 1; #Q; scl = 1; #(2*Q); sda_m = 0; #(2*Q); scl = 0;
  endtask

  task automatic stop_c();
    #Q; sda_m = 0; #Q; scl = 1; #(2*Q); sda_m = 1; #(2*Q);
  endtask

  task automatic send(logic [7:0] b, output logic ackb);
    for (int i = 7; i >= 0; i--) begin
      #Q; sda_m = b[i]; #Q; scl = 1; #(2*Q); scl = 0;
    end
    #Q; sda_m = 1; #Q; scl = 1; #Q; ackb = sda_bus; #Q; scl = 0;
  endtask

  task automatic recv(logic nack, output logic [7:0] d);
    logic s0, s1;
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      #(2*Q); scl = 1; #(Q/2); s0 = sda_bus; #Q; s1 = sda_bus;
      d[i] = s0;
      if (s0 !== s1) begin
        checks++; fails++;
        $display("FAIL R12 actual=%0b expected=%0b", s1, s0);
      end
      #(Q/2); scl = 0;
    end
    #Q; sda_m = nack; #Q; scl = 1; #(2*Q); scl = 0;
  endtask

  task automatic set_ptr(logic w, logic [15:0] p);
    logic a;
    wide = w;
    start_c();
    send({ADDR, 1'b0}, a); chk("R2 address ack", 8'(a), 8'h0);
    if (w) begin send(p[15:8], a); chk("R6 upper index ack", 8'(a), 8'h0); end
    send(p[7:0], a); chk(w ? "R6 lower index ack" : "R5 index ack", 8'(a), 8'h0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int idx;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk("R1 reset release", 8'(drv), 8'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", 8'(drv), 8'h0);

    // table: write one byte, then random read through repeated START
    for (int v = 0; v < 8; v++) begin
      idx = int'(VEC[v][23:8]) % DEPTH;
      set_ptr(VEC[v][24], VEC[v][23:8]);
      send(VEC[v][7:0], a); chk("R7 data ack", 8'(a), 8'h0);
      model[idx] = VEC[v][7:0];
      stop_c();
      chk("R1 release after STOP", 8'(drv), 8'h0);
      set_ptr(VEC[v][24], VEC[v][23:8]);
      start_c();
      send({ADDR, 1'b1}, a); chk("R10 read address ack", 8'(a), 8'h0);
      recv(1'b1, d); chk("R10 R6 read back", d, model[idx]);
      stop_c();
    end

    // burst write across the array end
    set_ptr(1'b0, 16'd14);
    for (int k = 0; k < 4; k++) begin
      send(8'hA0 + 8'(k), a); chk("R7 burst ack", 8'(a), 8'h0);
      model[(14 + k) % DEPTH] = 8'hA0 + 8'(k);
    end
    stop_c();
    // burst read across the array end
    set_ptr(1'b0, 16'd14);
    start_c();
    send({ADDR, 1'b1}, a); chk("R4 read ack", 8'(a), 8'h0);
    for (int k = 0; k < 4; k++) begin
      recv(k == 3, d); chk("R8 R11 burst read", d, model[(14 + k) % DEPTH]);
    end
    recv(1'b1, d); chk("R9 released after NACK", d, 8'hFF);
    stop_c();
    // plain read continues at the advanced index (2)
    start_c();
    send({ADDR, 1'b1}, a); chk("R4 read ack", 8'(a), 8'h0);
    recv(1'b1, d); chk("R4 R8 read at current index", d, model[2]);
    stop_c();

    // wrong address: no ACK, writes ignored
    set_ptr(1'b0, 16'd3);
    send(8'h3C, a); chk("R7 data ack", 8'(a), 8'h0);
    model[3] = 8'h3C;
    stop_c();
    start_c();
    send({7'h51, 1'b0}, a); chk("R3 no ack on mismatch", 8'(a), 8'h1);
    send(8'h03, a); chk("R3 byte ignored", 8'(a), 8'h1);
    send(8'hEE, a); chk("R3 byte ignored", 8'(a), 8'h1);
    stop_c();
    start_c();
    send({7'h51, 1'b1}, a); chk("R3 no ack on mismatched read", 8'(a), 8'h1);
    recv(1'b1, d); chk("R3 no data on mismatch", d, 8'hFF);
    stop_c();
    set_ptr(1'b0, 16'd3);
    start_c();
    send({ADDR, 1'b1}, a); chk("R10 read ack", 8'(a), 8'h0);
    recv(1'b1, d); chk("R3 register unchanged", d, 8'h3C);
    stop_c();
    chk("R1 idle at end", 8'(drv), 8'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule